// File: doc/BRIEF.md
# Two-Stage Serial Converter Code Register

This block is the digital input stage of a serial-fed digital-to-analogue converter. It works in a single system-clock domain. It oversamples four asynchronous lines: a serial clock, a serial data bit, an active-low word frame and an active-low load input. A serial bit is taken on each rising edge of the serial clock, but only while the frame line is low. Bits are assembled most significant first into a shift register.

When the frame closes with exactly one word length of bits, the assembled word is committed to a holding rank. A frame of any other length is discarded and raises an error flag. A second rank drives the code seen by the converter core. It copies the holding rank while the load signal is low and freezes the code on the load signal's rising edge.

The load signal comes from one of two sources, chosen by a parameter. It is either the external load pin or an internal strobe. The internal strobe samples the frame line on every serial clock rising edge, so it rises one serial clock after the frame ends.

Top module: `sdi_code_reg`

## Requirements
- R1: After a synchronous reset, `dac_code` is 0, `frame_err` is 0 and `load_strobe` is 1 (hold).
- R2: A frame of exactly 16 serial clock rising edges, with the load signal low, sets `dac_code` to the received word. The first bit received lands in bit 15 and the last bit received lands in bit 0.
- R3: Serial clock rising edges while `frame_n` is high do not change the word that is assembled or the code that is output.
- R4: A frame with fewer than 16 clock edges sets `frame_err` to 1 and leaves `dac_code` unchanged.
- R5: A frame with more than 16 clock edges sets `frame_err` to 1 and leaves `dac_code` unchanged.
- R6: A frame with exactly 16 clock edges clears `frame_err` to 0.
- R7: While the load signal is held high, a complete frame does not change `dac_code`.
- R8: When the load signal falls, `dac_code` takes the last word that was committed. After a rising edge of the load signal, later frames do not alter `dac_code` until the load signal is low again.
- R9: With `USE_LOAD_GEN=1`, the external `load_n` input is ignored. `load_strobe` goes low at the first serial clock rise inside a frame and goes high at the first serial clock rise after the frame ends, so the code settles to the committed word and is then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Asynchronous serial clock, rising edge samples data |
| sdata | input | 1 | Serial data bit |
| frame_n | input | 1 | Active-low word frame |
| load_n | input | 1 | External load, low = second rank transparent |
| dac_code | output | 16 | Code presented to the converter core |
| frame_err | output | 1 | Last frame had a wrong bit count |
| load_strobe | output | 1 | Effective load level used by the second rank |

## Verification
The in-module properties check these rules on every cycle:
- the shift register is stable when there is no qualified serial clock edge;
- the holding rank changes only after a frame that closed with a full count;
- the error flag rises only just after a frame end;
- the output code is stable in any cycle that follows a high load level;
- the generated strobe moves only on serial clock edges.

Only the bench scenarios show the following, because they depend on whole serial sequences:
- that bit order is most significant first;
- that short and long frames leave the output untouched;
- that a held word appears when the load signal falls;
- that the generated strobe opens and closes the second rank around a frame.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  // bundle of the asynchronous serial pins after synchronisation
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic frame_n;
    logic load_n;
  } sdi_lines_t;

  localparam int LINES_W = $bits(sdi_lines_t);
  // idle levels of the pins: clocks low, frame and load inactive (high)
  localparam sdi_lines_t LINES_IDLE = '{sclk: 1'b0, sdata: 1'b0, frame_n: 1'b1, load_n: 1'b1};
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  sdi_pkg::sdi_lines_t din,
  output sdi_pkg::sdi_lines_t dout
);
  sdi_pkg::sdi_lines_t pipe [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= sdi_pkg::LINES_IDLE;
          else     pipe[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= sdi_pkg::LINES_IDLE;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sdi_shift.sv
module sdi_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sdata_s,
  input  logic              frame_n_s,
  input  logic              frame_end,
  output logic [WORD_W-1:0] word,
  output logic              err
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              take;

  assign take = sclk_rise && !frame_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (frame_end) begin
      cnt <= '0;
    end else if (take) begin
      shreg <= {shreg[WORD_W-2:0], sdata_s};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      err  <= 1'b0;
    end else if (frame_end) begin
      if (cnt == CNT_FULL) begin
        word <= shreg;
        err  <= 1'b0;
      end else begin
        err  <= 1'b1;
      end
    end
  end

  // R3
  shreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(shreg));
  // R4
  word_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_end && cnt == CNT_FULL) |=> $stable(word));
  // R5
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(frame_end));
endmodule

// File: rtl/sdi_loadgen.sv
module sdi_loadgen (
  input  logic clk,
  input  logic rst,
  input  logic sclk_rise,
  input  logic frame_n_s,
  output logic strobe
);
  // one serial-clock delay of the frame line
  always_ff @(posedge clk) begin
    if (rst)            strobe <= 1'b1;
    else if (sclk_rise) strobe <= frame_n_s;
  end

  // R9
  strobe_step_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(strobe));
endmodule

// File: rtl/sdi_code_reg.sv
module sdi_code_reg #(
  parameter int WORD_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter bit USE_LOAD_GEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              frame_n,
  input  logic              load_n,
  output logic [WORD_W-1:0] dac_code,
  output logic              frame_err,
  output logic              load_strobe
);
  sdi_pkg::sdi_lines_t pins, pins_s;
  logic sclk_d, frame_d;
  logic sclk_rise, frame_end;
  logic [WORD_W-1:0] rank1;
  logic load_eff;

  assign pins = '{sclk: sclk, sdata: sdata, frame_n: frame_n, load_n: load_n};

  sdi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins), .dout(pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      frame_d <= 1'b1;
    end else begin
      sclk_d  <= pins_s.sclk;
      frame_d <= pins_s.frame_n;
    end
  end

  assign sclk_rise = pins_s.sclk && !sclk_d;
  assign frame_end = pins_s.frame_n && !frame_d;

  sdi_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sdata_s(pins_s.sdata),
    .frame_n_s(pins_s.frame_n), .frame_end(frame_end),
    .word(rank1), .err(frame_err)
  );

  generate
    if (USE_LOAD_GEN) begin : g_gen
      sdi_loadgen u_lgen (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise),
        .frame_n_s(pins_s.frame_n), .strobe(load_eff)
      );
    end else begin : g_ext
      assign load_eff = pins_s.load_n;
    end
  endgenerate

  // second rank: transparent while load is low
  always_ff @(posedge clk) begin
    if (rst)            dac_code <= '0;
    else if (!load_eff) dac_code <= rank1;
  end

  assign load_strobe = load_eff;

  // R8
  code_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    load_eff |=> $stable(dac_code));
endmodule

// File: tb/sim_sdi_code_reg.sv
module sim_sdi_code_reg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, frame_n = 1'b1, load_n = 1'b0;
  logic [15:0] code0, code1;
  logic err0, err1, lstr0, lstr1;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdi_code_reg u0 (.clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .frame_n(frame_n),
    .load_n(load_n), .dac_code(code0), .frame_err(err0), .load_strobe(lstr0));

  sdi_code_reg #(.USE_LOAD_GEN(1'b1)) u1 (.clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata),
    .frame_n(frame_n), .load_n(load_n), .dac_code(code1), .frame_err(err1), .load_strobe(lstr1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] data, input int nbits);
    frame_n = 1'b0; wclk(6);
    for (int i = 0; i < nbits; i++) begin
      sdata = data[nbits-1-i];
      pulse();
    end
    wclk(4); frame_n = 1'b1; wclk(12);
  endtask

  task automatic do_reset();
    rst = 1'b1; wclk(4); rst = 1'b0; wclk(4);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 code", code0, 0);
    chk("R1 err", err0, 0);
    chk("R1 strobe", lstr1, 1);
  endtask

  task automatic t_msb_first();
    load_n = 1'b0; wclk(6);
    send(32'h0000_A5C3, 16);
    chk("R2 word A5C3", code0, 16'hA5C3);
    send(32'h0000_8001, 16);
    chk("R2 word 8001", code0, 16'h8001);
  endtask

  task automatic t_idle_clocks();
    sdata = 1'b1;
    repeat (5) pulse();
    wclk(12);
    chk("R3 idle clocks keep code", code0, 16'h8001);
    send(32'h0000_1234, 16);
    chk("R3 word after idle clocks", code0, 16'h1234);
  endtask

  task automatic t_short_long();
    send(32'h0000_00FF, 8);
    chk("R4 short err", err0, 1);
    chk("R4 short code", code0, 16'h1234);
    send(32'h0000_1234, 16);
    chk("R6 err clear", err0, 0);
    send(32'h0001_FFFF, 17);
    chk("R5 long err", err0, 1);
    chk("R5 long code", code0, 16'h1234);
    send(32'h0000_4321, 16);
    chk("R6 err clear after long", err0, 0);
    chk("R6 code", code0, 16'h4321);
  endtask

  task automatic t_load();
    load_n = 1'b1; wclk(12);
    send(32'h0000_BEEF, 16);
    chk("R7 held code", code0, 16'h4321);
    chk("R7 strobe high", lstr0, 1);
    load_n = 1'b0; wclk(12);
    chk("R8 transparent", code0, 16'hBEEF);
    load_n = 1'b1; wclk(12);
    send(32'h0000_0F0F, 16);
    chk("R8 frozen", code0, 16'hBEEF);
    load_n = 1'b0; wclk(12);
    chk("R8 reopened", code0, 16'h0F0F);
  endtask

  task automatic t_loadgen();
    do_reset();
    load_n = 1'b1;
    chk("R9 strobe idle", lstr1, 1);
    send(32'h0000_C0DE, 16);
    chk("R9 strobe low after frame", lstr1, 0);
    chk("R9 code follows", code1, 16'hC0DE);
    pulse(); wclk(12);
    chk("R9 strobe high one clock later", lstr1, 1);
    repeat (3) pulse();
    wclk(12);
    chk("R9 held", code1, 16'hC0DE);
    send(32'h0000_0055, 8);
    pulse(); wclk(12);
    chk("R9 short err", err1, 1);
    chk("R9 short code", code1, 16'hC0DE);
  endtask

  initial begin
    t_reset();
    t_msb_first();
    t_idle_clocks();
    t_short_long();
    t_load();
    t_loadgen();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule